// File: doc/BRIEF.md
# Scanline Descriptor List Scheduler

This block feeds a chained descriptor DMA that streams one video line at a time to a pixel shifter. The active display is 320 x 240 at 8 bits per pixel. Each time the DMA reports that a line is finished, the block does three things:

- It advances its scanline and frame counters.
- It writes the descriptor list for the line after the one now starting into the idle half of a ping-pong pair of 8-word list buffers.
- It strobes the DMA with that buffer's start pointer.

Each descriptor is a pair of words: a transfer count in 32-bit words, then a byte address. A list ends with a pair of zero words.

Each line falls into one of three classes:

- **Vertical sync line.** It points at a prebuilt two-word sync command buffer.
- **Porch line.** It points at a prebuilt two-word dark-line command buffer.
- **Image line.** It chains three pieces: a three-word header (horizontal sync, back porch, pixel command), one framebuffer row, and a one-word front-porch command.

Image lines are doubled vertically, so each framebuffer row is shown on two consecutive output lines. The framebuffer base must be word aligned. A misaligned base is rounded down and raises a sticky error flag.

Top module: `scanline_list_sched`

## Requirements
- R1: After reset, `line_o` and `frame_o` are 0. Each `line_done_i` pulse advances `line_o` by one. The pulse that would make `line_o` equal TOTAL (VS+VBP+ACT+VFP, default 2+33+480+10=525) sets it to 0 instead and increments `frame_o`.
- R2: A list for a line in [0, VS) is the words 2, `sync_buf_i`, 0, 0, written at word indices 0 to 3.
- R3: A list for a line in [VS, VS+VBP) or in [VS+VBP+ACT, TOTAL) is the words 2, `dark_buf_i`, 0, 0.
- R4: A list for an image line L in [VS+VBP, VS+VBP+ACT) is the words 3, `hdr_buf_i`, WIDTH/4, B + ((L-VS-VBP)>>1)*WIDTH, 1, `fp_buf_i`, 0, 0. Here B is the framebuffer base with bits [1:0] cleared.
- R5: The list written after a pulse that moves `line_o` to N is the list for line (N+1) mod TOTAL.
- R6: List buffer s occupies list-memory addresses {s, word[2:0]} (`lm_addr_o[3]` = s). Its DMA pointer is LIST_BASE + 32*s. The first pulse after reset fills buffer 0, and each following pulse fills the other buffer.
- R7: `dma_start_o` is a one-cycle strobe. It is high 4 clock edges after the edge that samples the pulse for a sync or porch list, and 8 edges after it for an image list. The last write is in the cycle just before the strobe.
- R8: After reset, the block writes the sync list of R2 into buffer 0 and then buffer 1, eight write cycles in all. It then strobes `dma_start_o` with the pointer to buffer 0.
- R9: `align_err_o` is 0 after reset. It goes to 1, and stays there until reset, when an image list is built while `fb_base_i[1:0]` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_done_i | input | 1 | One-cycle end-of-line pulse from the DMA |
| fb_base_i | input | AW | Framebuffer byte base address |
| sync_buf_i | input | AW | Address of the vertical-sync command pair |
| dark_buf_i | input | AW | Address of the dark-line command pair |
| hdr_buf_i | input | AW | Address of the three-word image-line header |
| fp_buf_i | input | AW | Address of the front-porch command word |
| lm_we_o | output | 1 | List-memory write enable |
| lm_addr_o | output | 4 | List-memory word address {buffer, index} |
| lm_data_o | output | AW | List-memory write data |
| dma_ptr_o | output | AW | Start pointer of the list just written |
| dma_start_o | output | 1 | Strobe telling the DMA the list is ready |
| line_o | output | LW | Current scanline number |
| frame_o | output | FW | Frame counter |
| align_err_o | output | 1 | Sticky misaligned-base flag |

## Verification
The counters change on the edge that samples the pulse. The list words appear one per cycle from the next cycle onward, and the start strobe comes 4 or 8 edges after that sampling edge, depending on the line class. The driver records the cycle number of the sampling edge with each expected list. It then reads the counters ten cycles later, when they are settled.

The monitor samples on falling edges. It stores every write into a shadow of the list memory. When it sees the strobe, it checks the following against the queued item, then clears that buffer so stale words cannot pass:
- the latency;
- the pointer;
- every word of the list.

// File: rtl/scanline_list_pkg.sv
// Shared types for the scanline descriptor list scheduler.
package scanline_list_pkg;
    // Class of a display line, which selects the list shape.
    typedef enum logic [1:0] {
        LK_SYNC   = 2'd0,
        LK_DARK   = 2'd1,
        LK_ACTIVE = 2'd2
    } line_kind_e;
endpackage

// File: rtl/scan_counter.sv
// Scanline and frame counters plus the running-buffer selector.
// Assumes step_i is a single-cycle pulse per finished line.
module scan_counter #(
    parameter int TOTAL = 525,
    parameter int LW    = 10,
    parameter int FW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    output logic [LW-1:0] line_o,
    output logic [FW-1:0] frame_o,
    output logic          run_sel_o
);
    localparam logic [LW-1:0] LAST = LW'(TOTAL - 1);

    // Advance the line, wrap at the frame end, swap the running buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_o    <= '0;
            frame_o   <= '0;
            run_sel_o <= 1'b0;
        end else if (step_i) begin
            run_sel_o <= ~run_sel_o;
            if (line_o == LAST) begin
                line_o  <= '0;
                frame_o <= frame_o + 1'b1;
            end else begin
                line_o <= line_o + 1'b1;
            end
        end
    end

    a_r1_line_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && line_o != LAST) |=> (line_o == $past(line_o) + 1'b1 && $stable(frame_o)));

    a_r1_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && line_o == LAST) |=> (line_o == '0 && frame_o == $past(frame_o) + 1'b1));
endmodule

// File: rtl/line_classify.sv
// Classifies the line two ahead of the current one and computes its
// framebuffer row address, with vertical doubling by halving the index.
// Assumes TOTAL > 2 and WIDTH a multiple of 4.
module line_classify
    import scanline_list_pkg::*;
#(
    parameter int VS    = 2,
    parameter int VBP   = 33,
    parameter int ACT   = 480,
    parameter int TOTAL = 525,
    parameter int LW    = 10,
    parameter int AW    = 32,
    parameter int WIDTH = 320
) (
    input  logic [LW-1:0] line_i,
    input  logic [AW-1:0] fb_base_i,
    output line_kind_e    kind_o,
    output logic [AW-1:0] row_addr_o,
    output logic          misalign_o
);
    localparam logic [LW:0] TOT_L  = (LW+1)'(TOTAL);
    localparam logic [LW:0] VS_L   = (LW+1)'(VS);
    localparam logic [LW:0] ACT_LO = (LW+1)'(VS + VBP);
    localparam logic [LW:0] ACT_HI = (LW+1)'(VS + VBP + ACT);

    logic [LW:0] sum, tgt, act_idx, row;

    // Target line = current + 1 (the line about to start) + 1 (one ahead).
    always_comb begin
        sum = {1'b0, line_i} + (LW+1)'(2);
        tgt = (sum >= TOT_L) ? sum - TOT_L : sum;
    end

    // Region tests by compare, row index by subtract and halve.
    always_comb begin
        act_idx = tgt - ACT_LO;
        row     = act_idx >> 1;
        if (tgt < VS_L)
            kind_o = LK_SYNC;
        else if (tgt >= ACT_LO && tgt < ACT_HI)
            kind_o = LK_ACTIVE;
        else
            kind_o = LK_DARK;
        row_addr_o = {fb_base_i[AW-1:2], 2'b00} + AW'(row) * AW'(WIDTH);
        misalign_o = |fb_base_i[1:0];
    end
endmodule

// File: rtl/list_writer.sv
// Writes one descriptor list, a word per cycle, into the idle list buffer
// and then strobes the DMA with its pointer. After reset it preloads both
// buffers with a sync list. Assumes line pulses are spaced wider than a
// list write (at least 10 cycles).
module list_writer
    import scanline_list_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          WIDTH     = 320,
    parameter logic [31:0] LIST_BASE = 32'h2000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          run_sel_i,
    input  line_kind_e    kind_i,
    input  logic [AW-1:0] row_addr_i,
    input  logic          misalign_i,
    input  logic [AW-1:0] sync_buf_i,
    input  logic [AW-1:0] dark_buf_i,
    input  logic [AW-1:0] hdr_buf_i,
    input  logic [AW-1:0] fp_buf_i,
    output logic          lm_we_o,
    output logic [3:0]    lm_addr_o,
    output logic [AW-1:0] lm_data_o,
    output logic [AW-1:0] dma_ptr_o,
    output logic          dma_start_o,
    output logic          align_err_o
);
    localparam logic [AW-1:0] BUF_BYTES = AW'(32);

    logic          busy, init, fill_sel, ptr_sel;
    logic [2:0]    idx;
    line_kind_e    kind_q;
    logic [AW-1:0] row_q;
    logic [2:0]    last_idx;

    assign last_idx = (kind_q == LK_ACTIVE) ? 3'd7 : 3'd3;

    // Sequencer: preload after reset, then one list per line pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b1;
            init        <= 1'b1;
            idx         <= '0;
            fill_sel    <= 1'b0;
            kind_q      <= LK_SYNC;
            row_q       <= '0;
            ptr_sel     <= 1'b0;
            dma_start_o <= 1'b0;
            align_err_o <= 1'b0;
        end else begin
            dma_start_o <= 1'b0;
            if (busy) begin
                if (idx == last_idx) begin
                    if (init && !fill_sel) begin
                        fill_sel <= 1'b1;
                        idx      <= '0;
                    end else begin
                        busy        <= 1'b0;
                        init        <= 1'b0;
                        dma_start_o <= 1'b1;
                        ptr_sel     <= init ? 1'b0 : fill_sel;
                    end
                end else begin
                    idx <= idx + 1'b1;
                end
            end else if (step_i) begin
                busy     <= 1'b1;
                idx      <= '0;
                fill_sel <= run_sel_i;
                kind_q   <= kind_i;
                row_q    <= row_addr_i;
                if (kind_i == LK_ACTIVE && misalign_i)
                    align_err_o <= 1'b1;
            end
        end
    end

    // Word selection for the list being written.
    always_comb begin
        lm_data_o = '0;
        unique case (kind_q)
            LK_ACTIVE: begin
                case (idx)
                    3'd0: lm_data_o = AW'(3);
                    3'd1: lm_data_o = hdr_buf_i;
                    3'd2: lm_data_o = AW'(WIDTH / 4);
                    3'd3: lm_data_o = row_q;
                    3'd4: lm_data_o = AW'(1);
                    3'd5: lm_data_o = fp_buf_i;
                    default: lm_data_o = '0;
                endcase
            end
            LK_SYNC, LK_DARK: begin
                case (idx)
                    3'd0: lm_data_o = AW'(2);
                    3'd1: lm_data_o = (kind_q == LK_SYNC) ? sync_buf_i : dark_buf_i;
                    default: lm_data_o = '0;
                endcase
            end
            default: lm_data_o = '0;
        endcase
    end

    assign lm_we_o   = busy;
    assign lm_addr_o = {fill_sel, idx};
    assign dma_ptr_o = AW'(LIST_BASE) + (ptr_sel ? BUF_BYTES : '0);

    a_r7_end_marker: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start_o |-> ($past(lm_we_o) && $past(lm_data_o) == '0));

    a_r9_row_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (lm_we_o && kind_q == LK_ACTIVE && lm_addr_o[2:0] == 3'd3) |-> (lm_data_o[1:0] == 2'b00));
endmodule

// File: rtl/scanline_list_sched.sv
// Top of the scanline descriptor list scheduler. Counts lines and frames,
// classifies the line one ahead, and builds its list into the idle half of
// a ping-pong list memory. Assumes ACT_LINES is even and VS_LINES >= 2.
module scanline_list_sched
    import scanline_list_pkg::*;
#(
    parameter int          VS_LINES  = 2,
    parameter int          VBP_LINES = 33,
    parameter int          ACT_LINES = 480,
    parameter int          VFP_LINES = 10,
    parameter int          WIDTH     = 320,
    parameter int          AW        = 32,
    parameter int          FW        = 16,
    parameter logic [31:0] LIST_BASE = 32'h2000_0000,
    localparam int         TOTAL     = VS_LINES + VBP_LINES + ACT_LINES + VFP_LINES,
    localparam int         LW        = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_done_i,
    input  logic [AW-1:0] fb_base_i,
    input  logic [AW-1:0] sync_buf_i,
    input  logic [AW-1:0] dark_buf_i,
    input  logic [AW-1:0] hdr_buf_i,
    input  logic [AW-1:0] fp_buf_i,
    output logic          lm_we_o,
    output logic [3:0]    lm_addr_o,
    output logic [AW-1:0] lm_data_o,
    output logic [AW-1:0] dma_ptr_o,
    output logic          dma_start_o,
    output logic [LW-1:0] line_o,
    output logic [FW-1:0] frame_o,
    output logic          align_err_o
);
    logic          run_sel;
    line_kind_e    kind;
    logic [AW-1:0] row_addr;
    logic          misalign;

    scan_counter #(.TOTAL(TOTAL), .LW(LW), .FW(FW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step_i(line_done_i),
        .line_o(line_o), .frame_o(frame_o), .run_sel_o(run_sel)
    );

    line_classify #(
        .VS(VS_LINES), .VBP(VBP_LINES), .ACT(ACT_LINES), .TOTAL(TOTAL),
        .LW(LW), .AW(AW), .WIDTH(WIDTH)
    ) u_cls (
        .line_i(line_o), .fb_base_i(fb_base_i),
        .kind_o(kind), .row_addr_o(row_addr), .misalign_o(misalign)
    );

    list_writer #(.AW(AW), .WIDTH(WIDTH), .LIST_BASE(LIST_BASE)) u_wr (
        .clk(clk), .rst_n(rst_n), .step_i(line_done_i), .run_sel_i(run_sel),
        .kind_i(kind), .row_addr_i(row_addr), .misalign_i(misalign),
        .sync_buf_i(sync_buf_i), .dark_buf_i(dark_buf_i),
        .hdr_buf_i(hdr_buf_i), .fp_buf_i(fp_buf_i),
        .lm_we_o(lm_we_o), .lm_addr_o(lm_addr_o), .lm_data_o(lm_data_o),
        .dma_ptr_o(dma_ptr_o), .dma_start_o(dma_start_o), .align_err_o(align_err_o)
    );

    // R6: once lines run, the buffer being written is never the running one.
    a_r6_fill_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (lm_we_o && (line_o != '0 || frame_o != '0)) |-> (lm_addr_o[3] != run_sel));
endmodule

// File: tb/scanline_list_sched_test.sv
module scanline_list_sched_test;
    localparam int VS = 2, VBP = 33, ACT = 480, VFP = 10, WIDTH = 320;
    localparam int TOTAL = VS + VBP + ACT + VFP;
    localparam logic [31:0] LBASE = 32'h2000_0000;
    localparam logic [31:0] SYNC_A = 32'h1100_0000, DARK_A = 32'h1100_0010;
    localparam logic [31:0] HDR_A = 32'h1100_0020, FP_A = 32'h1100_0030;

    logic clk = 0, rst_n = 0, line_done = 0;
    logic [31:0] fb_base = 32'h1000_0000;
    logic lm_we, dma_start, align_err;
    logic [3:0] lm_addr;
    logic [31:0] lm_data, dma_ptr;
    logic [9:0] line_v;
    logic [15:0] frame_v;

    scanline_list_sched uut (
        .clk(clk), .rst_n(rst_n), .line_done_i(line_done), .fb_base_i(fb_base),
        .sync_buf_i(SYNC_A), .dark_buf_i(DARK_A), .hdr_buf_i(HDR_A), .fp_buf_i(FP_A),
        .lm_we_o(lm_we), .lm_addr_o(lm_addr), .lm_data_o(lm_data),
        .dma_ptr_o(dma_ptr), .dma_start_o(dma_start),
        .line_o(line_v), .frame_o(frame_v), .align_err_o(align_err)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct packed {
        int               c0;
        int               lat;
        logic             sel;
        int               len;
        logic [7:0][31:0] w;
    } exp_t;

    exp_t q[$];
    logic [31:0] mem [16];
    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected list for a target line (R2, R3, R4).
    function automatic exp_t make_list(input int tgt, input logic [31:0] base);
        exp_t e;
        e = '0;
        if (tgt < VS) begin
            e.len = 4; e.w[0] = 2; e.w[1] = SYNC_A;
        end else if (tgt >= VS + VBP && tgt < VS + VBP + ACT) begin
            e.len = 8; e.w[0] = 3; e.w[1] = HDR_A; e.w[2] = WIDTH / 4;
            e.w[3] = (base & 32'hFFFF_FFFC) + 32'((tgt - VS - VBP) / 2 * WIDTH);
            e.w[4] = 1; e.w[5] = FP_A;
        end else begin
            e.len = 4; e.w[0] = 2; e.w[1] = DARK_A;
        end
        return e;
    endfunction

    // Monitor: shadow the list memory and check each list on the start strobe.
    always @(negedge clk) begin
        if (rst_n) begin
            if (lm_we) mem[lm_addr] = lm_data;
            if (dma_start) begin
                if (q.size() == 0) begin
                    chk(0, "R7", "unexpected start", 32'(dma_ptr), 32'hFFFF_FFFF);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(dma_ptr == LBASE + (e.sel ? 32'd32 : 32'd0), "R6", "pointer",
                        dma_ptr, LBASE + (e.sel ? 32'd32 : 32'd0));
                    if (e.lat >= 0)
                        chk((cyc - e.c0) == e.lat, "R7", "start latency",
                            32'(cyc - e.c0), 32'(e.lat));
                    for (int i = 0; i < e.len; i++)
                        chk(mem[{e.sel, 3'(i)}] == e.w[i], "R2/R3/R4 list word",
                            $sformatf("word %0d", i), mem[{e.sel, 3'(i)}], e.w[i]);
                    for (int i = 0; i < 8; i++) mem[{e.sel, 3'(i)}] = 32'hDEAD_BEEF;
                end
            end
        end
    end

    int exp_line = 0, exp_frame = 0;
    logic exp_run = 0;

    // Driver: one line pulse, queue the expected list, then check counters.
    task automatic line_pulse();
        exp_t e;
        int tgt;
        @(negedge clk);
        line_done = 1;
        exp_line = (exp_line + 1) % TOTAL;
        if (exp_line == 0) exp_frame++;
        tgt = (exp_line + 1) % TOTAL;  // R5: one line ahead
        e = make_list(tgt, fb_base);
        e.c0 = cyc + 1;
        e.lat = (e.len == 8) ? 8 : 4;
        e.sel = exp_run;
        exp_run = ~exp_run;
        q.push_back(e);
        @(negedge clk);
        line_done = 0;
        repeat (10) @(negedge clk);
        chk(line_v == 10'(exp_line), "R1", "line", 32'(line_v), 32'(exp_line));
        chk(frame_v == 16'(exp_frame), "R1", "frame", 32'(frame_v), 32'(exp_frame));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        exp_t e;
        for (int i = 0; i < 16; i++) mem[i] = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        // R8/R1: reset state
        chk(line_v == 0, "R1", "reset line", 32'(line_v), 0);
        chk(frame_v == 0, "R1", "reset frame", 32'(frame_v), 0);
        chk(dma_start == 0, "R8", "no start in reset", 32'(dma_start), 0);
        chk(align_err == 0, "R9", "reset error flag", 32'(align_err), 0);
        // R8: preload both buffers, then start on buffer 0
        e = make_list(0, fb_base);
        e.lat = -1; e.sel = 0; e.c0 = 0;
        q.push_back(e);
        rst_n = 1;
        repeat (12) @(negedge clk);
        chk(q.size() == 0, "R8", "initial start seen", 32'(q.size()), 0);
        chk(mem[8] == 2, "R8", "buffer 1 count", mem[8], 2);
        chk(mem[9] == SYNC_A, "R8", "buffer 1 address", mem[9], SYNC_A);
        chk(mem[10] == 0 && mem[11] == 0, "R8", "buffer 1 end", mem[10] | mem[11], 0);

        // Sync, back porch and first image lines with an aligned base.
        for (int n = 0; n < 100; n++) line_pulse();
        chk(align_err == 0, "R9", "aligned base keeps flag low", 32'(align_err), 0);

        // R9: misaligned base is rounded down and flags an error.
        fb_base = 32'h1000_0102;
        line_pulse();
        chk(align_err == 1, "R9", "misaligned flag set", 32'(align_err), 1);
        fb_base = 32'h1000_0000;
        line_pulse();
        chk(align_err == 1, "R9", "flag sticky", 32'(align_err), 1);

        // Rest of the frame through the front porch and the wrap (R1, R3, R5).
        for (int n = 0; n < TOTAL - 102 + 5; n++) line_pulse();
        chk(frame_v == 1, "R1", "frame after wrap", 32'(frame_v), 1);
        repeat (5) @(negedge clk);
        chk(q.size() == 0, "R7", "all lists started", 32'(q.size()), 0);
        finish_run();
    end
endmodule